// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock of an I2C bus while the controller is the bus master, in either the transmit or the receive direction. A 3-bit rate-select input chooses one of eight fixed divide ratios of the system clock. The block acts on the wire only through an open-drain style output. When `scl_pull_low` is 1 the line is pulled low. When it is 0 the line is left to its pull-up. The block reads the real bus level back through `scl_in`. This lets it share the wire with other masters, which form a wired-AND clock, and with devices that hold the clock low to slow the transfer.

The core is a four-state machine. **ST_IDLE** leaves the line released while the master enable is low, which covers every slave mode. **ST_LOW** holds the line low for one half period. **ST_WAIT_HIGH** has released the line and waits for the synchronized bus level to read high. **ST_HIGH** counts out the rest of the high half period.

The transitions are:
- `idle_to_low`: the enable is seen high.
- `low_done`: the low count expires.
- `seen_high`: the synchronized input reads high.
- `high_done`: the high count expires.
- `forced_low`: another device pulls the line low during ST_HIGH.
- `disable`: from any state to ST_IDLE when the enable drops.

The high count is preloaded with the input synchronizer latency. With no other device on the wire, the released time therefore equals the low time, which gives a 50% duty cycle.

Top module: `i2c_scl_master_clkgen`

## Requirements
- R1: While reset is asserted and on the first clock after it, `scl_pull_low` is 0 (line released).
- R2: While `master_en` is 0, `scl_pull_low` stays 0 whatever `rate_sel` and the bus level do.
- R3: At the first rising edge where `master_en` is sampled 1 in ST_IDLE, `scl_pull_low` becomes 1, so a clock period starts with its low half.
- R4: A low half lasts H = BASE_HALF * 2^rate_sel clock cycles. With the default BASE_HALF of 8, `rate_sel` 3'd0 gives 8 cycles and 3'd7 gives 1024 cycles.
- R5: With no other device driving the line, the line is released for exactly H cycles between low halves, giving a period of 2H with a 50% duty cycle.
- R6: If another device holds the bus low for S cycles after the block releases it, the block stays released for S + H cycles. The high count begins only once the synchronized bus level reads high.
- R7: If the bus is pulled low by another device while ST_HIGH is counting, `scl_pull_low` becomes 1 at the (SYNC_STAGES+1)th rising edge after the bus went low. That is the 3rd edge with the default SYNC_STAGES of 2. A full low half of H cycles then follows.
- R8: `rate_sel` is captured only when a low half begins. A change made during a period takes effect at the next low half.
- R9: When `master_en` is sampled 0 at a rising edge, `scl_pull_low` is 0 after that edge, whatever the state. A later enable starts a fresh low half of full length H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1 while the controller is bus master (transmit or receive); 0 in slave modes |
| rate_sel | input | 3 | Divide ratio select, half period = BASE_HALF << rate_sel |
| scl_in | input | 1 | Bus clock level read back from the pad |
| scl_pull_low | output | 1 | 1 pulls the bus clock low, 0 releases it |

## Verification
The bench wires the output into a wired-AND bus model together with a second, bench-controlled device. It then measures half-period lengths in clock cycles. The tests cover the following cases:
- **Clock stretch.** A design that counts the high half from the moment it releases the line would shorten the high time after a stretch, instead of giving S + H.
- **Early pull-low during the high count.** A design that ignores it would keep counting and fall out of step with the other master.
- **Rate change in mid-period.** A design that reads `rate_sel` continuously would produce a low half of mixed length.
- **Disable in the middle of a low half.** A design with a late or missing release would keep the line low in a slave mode.
- **All eight rates.** These catch an off-by-one in the divider or in the latency preload. Either error breaks the 50% duty cycle.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_LOW       = 2'd1,
        ST_WAIT_HIGH = 2'd2,
        ST_HIGH      = 2'd3
    } scl_state_e;

endpackage

// File: rtl/sclgen_sync.sv
module sclgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[gi] <= 1'b1;
                    else        chain[gi] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[gi] <= 1'b1;
                    else        chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sclgen_rate.sv
module sclgen_rate #(
    parameter int BASE_HALF = 8,
    parameter int SEL_W     = 3,
    parameter int CW        = 11
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CW-1:0]    half
);
    localparam int NRATES = 1 << SEL_W;

    logic [CW-1:0] ratio_tbl [NRATES];

    generate
        for (genvar gi = 0; gi < NRATES; gi++) begin : g_ratio
            assign ratio_tbl[gi] = CW'(BASE_HALF << gi);
        end
    endgenerate

    assign half = ratio_tbl[sel];
endmodule

// File: rtl/sclgen_fsm.sv
module sclgen_fsm
    import sclgen_pkg::*;
#(
    parameter int CW          = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [CW-1:0] half_in,
    input  logic          line_high,
    output logic          pull_low
);
    localparam logic [CW-1:0] PRELOAD = CW'(SYNC_STAGES + 1);
    localparam logic [CW-1:0] ONE     = CW'(1);

    scl_state_e    state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [CW-1:0] half_q;
    logic          pull_q;
    logic          phase_last;

    assign phase_last = (cnt_q == half_q - ONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // next state and counter
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (!run_en) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_n = ST_LOW;
                    cnt_n   = '0;
                end
                ST_LOW: begin
                    if (phase_last) begin
                        state_n = ST_WAIT_HIGH;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + ONE;
                    end
                end
                ST_WAIT_HIGH: begin
                    if (line_high) begin
                        state_n = ST_HIGH;
                        cnt_n   = PRELOAD;
                    end
                end
                ST_HIGH: begin
                    if (!line_high || phase_last) begin
                        state_n = ST_LOW;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + ONE;
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            half_q <= half_in;
        end else begin
            cnt_q <= cnt_n;
            if (state_n == ST_LOW && state_q != ST_LOW) half_q <= half_in;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pull_q <= 1'b0;
        else        pull_q <= (state_n == ST_LOW);
    end

    assign pull_low = pull_q;
endmodule

// File: rtl/i2c_scl_master_clkgen.sv
module i2c_scl_master_clkgen #(
    parameter int BASE_HALF   = 8,
    parameter int RATE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              scl_in,
    output logic              scl_pull_low
);
    localparam int MAX_HALF = BASE_HALF << ((1 << RATE_W) - 1);
    localparam int CW       = $clog2(MAX_HALF) + 1;

    logic          scl_sync;
    logic [CW-1:0] half_cycles;

    sclgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (scl_in),
        .dout (scl_sync)
    );

    sclgen_rate #(.BASE_HALF(BASE_HALF), .SEL_W(RATE_W), .CW(CW)) u_rate (
        .sel (rate_sel),
        .half(half_cycles)
    );

    sclgen_fsm #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (master_en),
        .half_in  (half_cycles),
        .line_high(scl_sync),
        .pull_low (scl_pull_low)
    );
endmodule

// File: rtl/sclgen_chk.sv
module sclgen_chk #(
    parameter int BASE_HALF = 8,
    parameter int RATE_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_en,
    input logic [RATE_W-1:0] rate_sel,
    input logic              scl_pull_low
);
    localparam int CW = $clog2(BASE_HALF << ((1 << RATE_W) - 1)) + 2;

    logic              pull_d;
    logic [RATE_W-1:0] sel_d;
    logic [CW-1:0]     low_cnt;
    logic [CW-1:0]     low_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pull_d  <= 1'b0;
            sel_d   <= '0;
            low_cnt <= '0;
            low_cap <= '0;
        end else begin
            pull_d <= scl_pull_low;
            sel_d  <= rate_sel;
            if (scl_pull_low && !pull_d) begin
                low_cnt <= CW'(1);
                low_cap <= CW'(BASE_HALF) << sel_d;
            end else if (scl_pull_low) begin
                low_cnt <= low_cnt + CW'(1);
            end
        end
    end

    // R3: a low half only begins while the master enable is set
    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_low) |-> $past(master_en));

    // R4: an undisturbed low half lasts exactly the captured half period
    assert_low_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_pull_low) && $past(master_en)) |-> (low_cnt == low_cap));

    // R4: the low count never runs past its half period
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull_low && pull_d) |-> (low_cnt <= low_cap));

    // R9: the line is released on the edge after the enable is seen low
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !scl_pull_low);
endmodule

bind i2c_scl_master_clkgen sclgen_chk #(.BASE_HALF(BASE_HALF), .RATE_W(RATE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_en   (master_en),
    .rate_sel    (rate_sel),
    .scl_pull_low(scl_pull_low)
);

// File: tb/sim_i2c_scl_master_clkgen.sv
`timescale 1ns/1ps
module sim_i2c_scl_master_clkgen;
    localparam int BASE = 8;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_en = 1'b0;
    logic [2:0] rate_sel = 3'd0;
    logic       other_low = 1'b0;
    logic       scl_pull_low;
    wire        scl_bus = ~(scl_pull_low | other_low);

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    i2c_scl_master_clkgen #(.BASE_HALF(BASE), .RATE_W(3), .SYNC_STAGES(SYNC)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_en   (master_en),
        .rate_sel    (rate_sel),
        .scl_in      (scl_bus),
        .scl_pull_low(scl_pull_low)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (scl_pull_low == lvl) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic restart(input logic [2:0] sel);
        master_en = 1'b0;
        @(negedge clk);
        rate_sel  = sel;
        master_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_r1;
        @(negedge clk);
        check("R1 released in reset", int'(scl_pull_low), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 released after reset", int'(scl_pull_low), 0);
    endtask

    task automatic t_disabled_r2;
        int hits = 0;
        for (int i = 0; i < 40; i++) begin
            rate_sel  = 3'(i);
            other_low = i[2];
            @(negedge clk);
            if (scl_pull_low) hits++;
        end
        other_low = 1'b0;
        check("R2 no pull while disabled", hits, 0);
    endtask

    task automatic t_rates_r3_r4_r5;
        int lo, hi;
        for (int s = 0; s < 8; s++) begin
            restart(3'(s));
            if (s == 0) check("R3 first edge pulls low", int'(scl_pull_low), 1);
            run_len(1'b1, lo);
            run_len(1'b0, hi);
            check($sformatf("R4 low half sel=%0d", s), lo, BASE << s);
            check($sformatf("R5 high half sel=%0d", s), hi, BASE << s);
        end
    endtask

    task automatic t_stretch_r6;
        int lo, hi, held;
        restart(3'd1);
        run_len(1'b1, lo);
        other_low = 1'b1;
        held = 0;
        repeat (20) begin
            held++;
            @(negedge clk);
        end
        other_low = 1'b0;
        run_len(1'b0, hi);
        check("R6 stretched release", held + hi, 20 + 16);
        run_len(1'b1, lo);
        check("R6 low after stretch", lo, 16);
    endtask

    task automatic t_early_r7;
        int lo, m;
        restart(3'd2);
        run_len(1'b1, lo);
        repeat (10) @(negedge clk);
        other_low = 1'b1;
        run_len(1'b0, m);
        check("R7 reaction edges", m, SYNC + 1);
        other_low = 1'b0;
        run_len(1'b1, lo);
        check("R7 full low after forced", lo, 32);
    endtask

    task automatic t_rate_change_r8;
        int a, b, c;
        restart(3'd0);
        rate_sel = 3'd1;
        run_len(1'b1, a);
        run_len(1'b0, b);
        run_len(1'b1, c);
        check("R8 current low keeps old rate", a, 8);
        check("R8 current high keeps old rate", b, 8);
        check("R8 next low uses new rate", c, 16);
    endtask

    task automatic t_disable_r9;
        int lo, hits;
        restart(3'd3);
        repeat (5) @(negedge clk);
        master_en = 1'b0;
        @(negedge clk);
        check("R9 release after disable", int'(scl_pull_low), 0);
        hits = 0;
        repeat (3) begin
            @(negedge clk);
            if (scl_pull_low) hits++;
        end
        check("R9 stays released", hits, 0);
        master_en = 1'b1;
        @(negedge clk);
        check("R9 reenable pulls low", int'(scl_pull_low), 1);
        run_len(1'b1, lo);
        check("R9 fresh full low", lo, 64);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_r1();
        t_disabled_r2();
        t_rates_r3_r4_r5();
        t_stretch_r6();
        t_early_r7();
        t_rate_change_r8();
        t_disable_r9();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule